// File: doc/BRIEF.md
# Programmable Event Match Unit

This block sits beside a processor pipeline and watches four groups of status signals: a combined interrupt and exception bus, a bank of micro-architectural event strobes, a set of mode indicators, and the opcode being handed to micro-op expansion. The opcode is taken there so that instruction-related events show up early. Software fills a small table of match entries through a one-entry-per-write port. Each entry picks one signal group and tests it either for one exact value or for membership in an inclusive window. Each entry also carries the signature number and the event number that it reports when it hits.

Every clock edge evaluates all valid entries against the sampled signals. Each hit becomes one (signature, event) tuple for a downstream signature monitor. Several entries can test the same signal, so one observation can feed several signatures, and each of those entries reports separately. Hits from the same edge are queued in an eight-deep output queue in ascending entry order. The queue releases one tuple per cycle. Hits that find no room are dropped, and a sticky flag records the loss.

Top module: `event_match_unit`

## Requirements
- R1: After reset, every table entry is invalid, no tuple is presented (`tup_valid_o` low) and `ovf_o` is low, even while the monitored inputs carry values.
- R2: An entry of kind equal (code 1) hits when its selected group, zero-extended to 16 bits, equals the low operand.
- R3: An entry of kind range (code 2) hits when low <= value <= high. Both ends are inclusive, and values one below low or one above high do not hit.
- R4: Kind codes 0 and 3 never hit, and an entry whose valid bit is clear never hits, whatever its operands.
- R5: Group select codes are 0 = interrupt/exception bus (15 bits), 1 = micro-architectural strobes (14 bits), 2 = mode indicators (11 bits), 3 = opcode (8 bits).
- R6: A hit presents the entry's 4-bit signature on `tup_sig_o` and its 3-bit event on `tup_evt_o`. Entries that test the same signal each produce their own tuple.
- R7: Inputs are sampled at a clock edge, and the first resulting tuple is visible right after that edge. When several entries hit on one edge, their tuples leave one per cycle in ascending entry index, behind any tuples already queued.
- R8: A table write at a clock edge affects only matching at later edges. The edge that performs the write still uses the previous contents of that entry.
- R9: The output queue holds 8 tuples and pops one per cycle while it is non-empty. When hits exceed the free space, the lowest-indexed hits are kept and the rest are dropped. `ovf_o` then rises and stays high until reset.
- R10: While `match_en` is low no new hit is recorded, but tuples already queued keep draining.
- R11: `cfg_data` layout, from MSB to LSB: valid[43], group[42:41], kind[40:39], low[38:23], high[22:7], signature[6:3], event[2:0]. `cfg_idx` selects the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_en | input | 1 | Global match enable |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_data | input | 44 | Entry contents (layout in R11) |
| irq_exc_i | input | 15 | Interrupt and exception predicates |
| uarch_ev_i | input | 14 | Micro-architectural event strobes |
| mode_i | input | 11 | Mode indicators |
| opcode_i | input | 8 | Opcode at micro-op expansion |
| tup_valid_o | output | 1 | Tuple present this cycle |
| tup_sig_o | output | 4 | Signature number of the tuple |
| tup_evt_o | output | 3 | Event number of the tuple |
| ovf_o | output | 1 | Sticky tuple-loss flag |

## Verification
The bench drives values exactly at and one step outside range limits. An exclusive comparison would lose the end points, and a loose one would add neighbours. It writes an entry on the same edge that its condition first holds, which catches a table that bypasses new contents into the compare. It also programs shared-signal entries out of index order, so a queue that orders by write time or by signature instead of by entry index shows up as swapped tuples. A sixteen-way simultaneous hit into an eight-deep queue checks that the lowest indices are kept, that the count never wraps, and that the loss flag stays set after the queue drains.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int OPND_W = 16;
  localparam int SIG_W  = 4;
  localparam int EVT_W  = 3;
  localparam int NGRP   = 4;

  typedef enum logic [1:0] {
    K_OFF   = 2'd0,
    K_EQ    = 2'd1,
    K_RANGE = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef struct packed {
    logic              valid;
    logic [1:0]        grp;
    kind_e             kind;
    logic [OPND_W-1:0] lo;
    logic [OPND_W-1:0] hi;
    logic [SIG_W-1:0]  sig;
    logic [EVT_W-1:0]  evt;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);

  typedef struct packed {
    logic [SIG_W-1:0] sig;
    logic [EVT_W-1:0] evt;
  } tuple_t;

  function automatic logic f_equal(input logic [OPND_W-1:0] v,
                                   input logic [OPND_W-1:0] lo);
    return v == lo;
  endfunction

  function automatic logic f_window(input logic [OPND_W-1:0] v,
                                    input logic [OPND_W-1:0] lo,
                                    input logic [OPND_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/emu_match_cell.sv
module emu_match_cell
  import emu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  entry_t            ent,
  input  logic [OPND_W-1:0] grp_val [NGRP],
  output logic              hit
);
  logic [OPND_W-1:0] sel_val;
  logic              cond;

  always_comb begin
    sel_val = grp_val[ent.grp];
    unique case (ent.kind)
      K_EQ:    cond = f_equal(sel_val, ent.lo);
      K_RANGE: cond = f_window(sel_val, ent.lo, ent.hi);
      default: cond = 1'b0;
    endcase
    hit = en && ent.valid && cond;
  end

  // R4: disabled kinds and invalid entries are silent
  p_quiet_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent.valid || ent.kind == K_OFF || ent.kind == K_RSVD) |-> !hit);
endmodule

// File: rtl/emu_tuple_fifo.sv
module emu_tuple_fifo
  import emu_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  hit_vec,
  input  tuple_t           tup_in [N_IN],
  output logic             out_valid,
  output tuple_t           out_tup,
  output logic             ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int KW = $clog2(N_IN + DEPTH + 1) + 1;

  tuple_t          mem [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   fifo_count;
  logic            pop;
  logic [KW-1:0]   space, rank, n_acc;
  logic            drop;
  logic [N_IN-1:0] take;
  logic [AW-1:0]   slot [N_IN];

  always_comb begin
    pop   = (fifo_count != '0);
    space = KW'(DEPTH) - KW'(fifo_count) + KW'(pop);
    rank  = '0;
    for (int i = 0; i < N_IN; i++) begin
      take[i] = hit_vec[i] && (rank < space);
      slot[i] = wr_ptr + rank[AW-1:0];
      if (hit_vec[i]) rank = rank + 1'b1;
    end
    n_acc = (rank < space) ? rank : space;
    drop  = rank > space;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      fifo_count <= '0;
      ovf        <= 1'b0;
    end else begin
      rd_ptr     <= rd_ptr + AW'(pop);
      wr_ptr     <= wr_ptr + n_acc[AW-1:0];
      fifo_count <= CW'(KW'(fifo_count) - KW'(pop) + n_acc);
      ovf        <= ovf | drop;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_IN; i++)
      if (take[i]) mem[slot[i]] <= tup_in[i];
  end

  assign out_valid = pop;
  assign out_tup   = mem[rd_ptr];

  // R9: occupancy never exceeds capacity
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  // R9: loss flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R7: with no new hits, the queue shrinks by exactly one per cycle
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count != '0 && hit_vec == '0) |=> fifo_count == $past(fifo_count) - 1'b1);
endmodule

// File: rtl/event_match_unit.sv
module event_match_unit
  import emu_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int FIFO_D = 8,
  parameter int IRQ_W  = 15,
  parameter int UEV_W  = 14,
  parameter int MODE_W = 11,
  parameter int OP_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     match_en,
  input  logic                     cfg_we,
  input  logic [$clog2(N_ENT)-1:0] cfg_idx,
  input  logic [ENT_W-1:0]         cfg_data,
  input  logic [IRQ_W-1:0]         irq_exc_i,
  input  logic [UEV_W-1:0]         uarch_ev_i,
  input  logic [MODE_W-1:0]        mode_i,
  input  logic [OP_W-1:0]          opcode_i,
  output logic                     tup_valid_o,
  output logic [SIG_W-1:0]         tup_sig_o,
  output logic [EVT_W-1:0]         tup_evt_o,
  output logic                     ovf_o
);
  entry_t            tbl [N_ENT];
  logic [OPND_W-1:0] grp_val [NGRP];
  logic [N_ENT-1:0]  hit_vec;
  tuple_t            tup_in [N_ENT];
  tuple_t            out_tup;

  assign grp_val[0] = OPND_W'(irq_exc_i);
  assign grp_val[1] = OPND_W'(uarch_ev_i);
  assign grp_val[2] = OPND_W'(mode_i);
  assign grp_val[3] = OPND_W'(opcode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      tbl[cfg_idx] <= entry_t'(cfg_data);
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cell
    emu_match_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (match_en),
      .ent     (tbl[g]),
      .grp_val (grp_val),
      .hit     (hit_vec[g])
    );
    assign tup_in[g] = '{sig: tbl[g].sig, evt: tbl[g].evt};
  end

  emu_tuple_fifo #(.N_IN(N_ENT), .DEPTH(FIFO_D)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_vec   (hit_vec),
    .tup_in    (tup_in),
    .out_valid (tup_valid_o),
    .out_tup   (out_tup),
    .ovf       (ovf_o)
  );

  assign tup_sig_o = out_tup.sig;
  assign tup_evt_o = out_tup.evt;

  // R10: no entry reports while matching is switched off
  p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !match_en |-> hit_vec == '0);
  // R7: a tuple appears only if the queue was loaded or already held one
  p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tup_valid_o && hit_vec == '0) |=> !tup_valid_o);
endmodule

// File: tb/test_event_match_unit.sv
module test_event_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        match_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [43:0] cfg_data = '0;
  logic [14:0] irq_exc_i = '0;
  logic [13:0] uarch_ev_i = '0;
  logic [10:0] mode_i = '0;
  logic [7:0]  opcode_i = '0;
  logic        tup_valid_o, ovf_o;
  logic [3:0]  tup_sig_o;
  logic [2:0]  tup_evt_o;

  event_match_unit i_event_match_unit (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  int m_valid [16], m_grp [16], m_kind [16], m_lo [16], m_hi [16], m_sig [16], m_evt [16];
  int mq [$];
  bit m_ovf = 0;

  function automatic bit m_hit(int i);
    int v;
    case (m_grp[i])
      0: v = int'(irq_exc_i);
      1: v = int'(uarch_ev_i);
      2: v = int'(mode_i);
      default: v = int'(opcode_i);
    endcase
    if (!m_valid[i]) return 0;
    if (m_kind[i] == 1) return v == m_lo[i];
    if (m_kind[i] == 2) return (v >= m_lo[i]) && (v <= m_hi[i]);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_ovf = 0;
      for (int i = 0; i < 16; i++) m_valid[i] = 0;
    end else begin
      if (mq.size() > 0) void'(mq.pop_front());
      if (match_en)
        for (int i = 0; i < 16; i++)
          if (m_hit(i)) begin
            if (mq.size() < 8) mq.push_back(m_sig[i] * 8 + m_evt[i]);
            else m_ovf = 1;
          end
      if (cfg_we) begin
        m_valid[cfg_idx] = int'(cfg_data[43]);
        m_grp[cfg_idx]   = int'(cfg_data[42:41]);
        m_kind[cfg_idx]  = int'(cfg_data[40:39]);
        m_lo[cfg_idx]    = int'(cfg_data[38:23]);
        m_hi[cfg_idx]    = int'(cfg_data[22:7]);
        m_sig[cfg_idx]   = int'(cfg_data[6:3]);
        m_evt[cfg_idx]   = int'(cfg_data[2:0]);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model comparison on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, int'(tup_valid_o), int'(mq.size() > 0));
      if (mq.size() > 0) chk(cur_req, int'({tup_sig_o, tup_evt_o}), mq[0]);
      chk(cur_req, int'(ovf_o), int'(m_ovf));
    end
  end

  task automatic wr(int idx, bit v, int grp, int kind, int lo, int hi, int sig, int evt);
    cfg_we   = 1'b1;
    cfg_idx  = 4'(idx);
    cfg_data = {v, 2'(grp), 2'(kind), 16'(lo), 16'(hi), 4'(sig), 3'(evt)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    irq_exc_i = 15'h7FFF; opcode_i = 8'hFF;
    idle(3);
    rst_n = 1'b1; match_en = 1'b1;
    idle(3);
    cur_req = "R1";
    chk("R1", int'(tup_valid_o), 0);
    chk("R1", int'(ovf_o), 0);

    // R8 / R2 / R11: write and matching value in the same cycle
    irq_exc_i = 15'h0123;
    cur_req = "R8";
    wr(0, 1, 0, 1, 16'h0123, 0, 5, 2);
    chk("R8", int'(tup_valid_o), 0);
    @(negedge clk);
    chk("R2", int'(tup_valid_o), 1);
    chk("R2", int'(tup_sig_o), 5);
    chk("R6", int'(tup_evt_o), 2);
    irq_exc_i = 15'h0124;
    cur_req = "R2";
    idle(3);
    chk("R2", int'(tup_valid_o), 0);

    // R3: inclusive window on strobe group
    cur_req = "R3";
    wr(1, 1, 1, 2, 10, 20, 3, 4);
    uarch_ev_i = 14'd9;  @(negedge clk); chk("R3", int'(tup_valid_o), 0);
    uarch_ev_i = 14'd10; @(negedge clk); chk("R3", int'(tup_valid_o), 1);
    uarch_ev_i = 14'd20; @(negedge clk); chk("R3", int'(tup_valid_o), 1);
    uarch_ev_i = 14'd21; @(negedge clk); chk("R3", int'(tup_valid_o), 0);
    uarch_ev_i = 14'd15; @(negedge clk); chk("R3", int'(tup_sig_o), 3);
    uarch_ev_i = 14'd0;  idle(2);

    // R5: opcode and mode groups, including the top of the mode range
    cur_req = "R5";
    wr(2, 1, 3, 1, 8'hA5, 0, 7, 1);
    wr(3, 1, 2, 2, 11'h7FF, 11'h7FF, 9, 6);
    opcode_i = 8'hA5; @(negedge clk); chk("R5", int'(tup_sig_o), 7);
    opcode_i = 8'h00; mode_i = 11'h7FF; @(negedge clk); chk("R5", int'(tup_sig_o), 9);
    mode_i = 11'h7FE; @(negedge clk); chk("R5", int'(tup_valid_o), 0);
    irq_exc_i = 15'h00A5; @(negedge clk); chk("R5", int'(tup_valid_o), 0);
    irq_exc_i = 15'h0; idle(2);

    // R6 / R7: shared signal, written out of index order
    cur_req = "R7";
    wr(9, 1, 3, 1, 8'h3C, 0, 12, 3);
    wr(4, 1, 3, 2, 8'h30, 8'h40, 11, 0);
    wr(5, 1, 3, 1, 8'h3C, 0, 2, 7);
    opcode_i = 8'h3C; @(negedge clk);
    opcode_i = 8'h00;
    chk("R7", int'(tup_sig_o), 11);
    @(negedge clk); chk("R7", int'(tup_sig_o), 2);
    @(negedge clk); chk("R6", int'(tup_sig_o), 12);
    @(negedge clk); chk("R7", int'(tup_valid_o), 0);

    // R4: disabled kinds and cleared valid bit
    cur_req = "R4";
    wr(6, 1, 0, 0, 16'h0055, 16'h0055, 1, 1);
    wr(7, 1, 0, 3, 16'h0055, 16'h0055, 1, 1);
    wr(8, 0, 0, 1, 16'h0055, 16'h0055, 1, 1);
    irq_exc_i = 15'h0055; idle(2);
    chk("R4", int'(tup_valid_o), 0);
    irq_exc_i = 15'h0;

    // R10: gate off, queued tuples still drain
    cur_req = "R10";
    opcode_i = 8'h3C; @(negedge clk);
    match_en = 1'b0; opcode_i = 8'hA5; @(negedge clk);
    chk("R10", int'(tup_sig_o), 2);
    @(negedge clk); chk("R10", int'(tup_sig_o), 12);
    @(negedge clk); chk("R10", int'(tup_valid_o), 0);
    idle(2);
    chk("R10", int'(tup_valid_o), 0);
    opcode_i = 8'h00;

    // R9: sixteen simultaneous hits into eight slots
    cur_req = "R9";
    for (int i = 0; i < 16; i++) wr(i, 1, 3, 2, 0, 8'hFF, i, i % 8);
    opcode_i = 8'h77; match_en = 1'b1; @(negedge clk);
    match_en = 1'b0;
    chk("R9", int'(ovf_o), 1);
    for (int k = 0; k < 8; k++) begin
      chk("R9", int'(tup_sig_o), k);
      @(negedge clk);
    end
    chk("R9", int'(tup_valid_o), 0);
    idle(3);
    chk("R9", int'(ovf_o), 1);

    // R1: reset clears flag and table
    cur_req = "R1";
    rst_n = 1'b0; idle(2); rst_n = 1'b1; match_en = 1'b1;
    idle(3);
    chk("R1", int'(ovf_o), 0);
    chk("R1", int'(tup_valid_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule